// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address for a synchronous burst memory. On a rising clock edge it can capture an external address when one of two address strobes is asserted. One strobe comes from the processor and the other from the memory controller. The captured address starts a four-word burst. After that, the low two address bits move forward inside the block on each cycle in which the advance input is high. The upper bits never change during the burst.

The stepping order is sampled from a mode input at the moment of the load. With the mode input high, the low bits count upward and wrap modulo four. With it low, which is also the tied-off default, the low bits are the loaded low bits XORed with a step count. The system does not have to use bursts. A fresh address can be loaded on any cycle and takes effect on the next edge with no lost cycle. Every input is sampled on the rising clock edge. The outputs come straight from registers through a small amount of logic, so they are valid for the whole cycle that follows the capturing edge.

Top module: `bseq_burst_addr`

## Requirements
- R1: While reset is high at a rising edge, the next cycle shows an all-zero address and a low burst-active flag.
- R2: A processor strobe with chip enable high loads `addr_in`. After that edge, `addr_out` equals the loaded address and `burst_active` is high.
- R3: A controller strobe with chip enable high loads `addr_in` in the same way, with `burst_active` high afterwards.
- R4: While chip enable is low, the processor strobe has no effect, so address and flag stay as they were. A controller strobe with chip enable low clears `burst_active` and leaves `addr_out` unchanged.
- R5: When both strobes are high with chip enable high, the processor strobe is the one that wins. The address is loaded and the burst restarts at its first word.
- R6: With `linear_mode` = 1 at the load, the low two bits after n advances equal (loaded low bits + n) mod 4.
- R7: With `linear_mode` = 0 at the load, the low two bits after n advances equal the loaded low bits XOR (n mod 4).
- R8: `addr_out` does not change on an edge where `advance` is low and no load occurs. It also does not change on an edge where `advance` is high but `burst_active` is low.
- R9: `addr_out[AW-1:2]` stays fixed from one load to the next. A fourth advance returns the address to the first word of the group.
- R10: A change of `linear_mode` after the load does not change the order of the burst in progress.
- R11: A load in the middle of a burst takes effect at once. The new address appears after that single edge and the step count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | AW | External word address |
| strobe_cpu | input | 1 | Processor address strobe, active high, gated by chip enable |
| strobe_ctl | input | 1 | Controller address strobe, active high |
| advance | input | 1 | Step the burst by one word |
| chip_en | input | 1 | Chip enable, active high |
| linear_mode | input | 1 | 1 = linear order, 0 = interleaved order (default) |
| addr_out | output | AW | Current word address |
| burst_active | output | 1 | High while a loaded burst is in progress |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. A load, a step or a deselect all show on `addr_out` and `burst_active` in the cycle after the capturing edge. The bench changes its inputs only at falling edges. It updates its reference state for the edge that follows, and then compares the outputs at the next falling edge, which lies half a period after the edge under test. Because of this timing, no comparison can pick up a value from the previous cycle or one from the cycle after.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Burst length is fixed at four words: two counted address bits.
    localparam int STEP_W = 2;

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic {
        ORDER_XOR = 1'b0,
        ORDER_INC = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2,
        CMD_STEP  = 2'd3
    } cmd_e;

    typedef struct packed {
        step_t  count;
        logic   active;
        order_e order;
    } seq_state_t;

    // Low address bits of the current word, from start bits and step count.
    function automatic step_t low_word(step_t start, step_t count, order_e ord);
        step_t r;
        if (ord == ORDER_INC) r = step_t'(start + count);
        else                  r = start ^ count;
        return r;
    endfunction

endpackage

// File: rtl/bseq_cmd_decode.sv
module bseq_cmd_decode
    import bseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_cpu,
    input  logic strobe_ctl,
    input  logic advance,
    input  logic chip_en,
    input  logic active,
    output cmd_e cmd
);

    logic cpu_ok;
    assign cpu_ok = strobe_cpu && chip_en;

    always_comb begin
        if (cpu_ok)
            cmd = CMD_LOAD;
        else if (strobe_ctl)
            cmd = chip_en ? CMD_LOAD : CMD_DESEL;
        else if (advance && active)
            cmd = CMD_STEP;
        else
            cmd = CMD_HOLD;
    end

    // R4
    cpu_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_cpu && !chip_en && !strobe_ctl) |-> (cmd != CMD_LOAD));

    // R5
    cpu_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_cpu && strobe_ctl && chip_en) |-> (cmd == CMD_LOAD));

endmodule

// File: rtl/bseq_step_ctr.sv
module bseq_step_ctr
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_e       cmd,
    input  logic       order_in,
    output seq_state_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st.count  <= '0;
            st.active <= 1'b0;
            st.order  <= ORDER_XOR;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    st.count  <= '0;
                    st.active <= 1'b1;
                    st.order  <= order_e'(order_in);
                end
                CMD_DESEL: st.active <= 1'b0;
                CMD_STEP:  st.count  <= step_t'(st.count + 1'b1);
                default:   ;
            endcase
        end
    end

    // R11
    load_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (st.count == '0 && st.active));

    // R6
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (st.count == step_t'($past(st.count) + 1'b1)));

    // R10
    order_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> $stable(st.order));

endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg
    import bseq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd,
    input  logic [AW-1:0] addr_in,
    input  seq_state_t    st,
    output logic [AW-1:0] addr_out
);

    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)                  base_q <= '0;
        else if (cmd == CMD_LOAD) base_q <= addr_in;
    end

    assign addr_out = {base_q[AW-1:STEP_W],
                       low_word(base_q[STEP_W-1:0], st.count, st.order)};

    // R2
    base_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (addr_out == $past(addr_in)));

    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> $stable(base_q));

endmodule

// File: rtl/bseq_burst_addr.sv
module bseq_burst_addr
    import bseq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_in,
    input  logic          strobe_cpu,
    input  logic          strobe_ctl,
    input  logic          advance,
    input  logic          chip_en,
    input  logic          linear_mode,
    output logic [AW-1:0] addr_out,
    output logic          burst_active
);

    cmd_e       cmd;
    seq_state_t st;

    bseq_cmd_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .advance    (advance),
        .chip_en    (chip_en),
        .active     (st.active),
        .cmd        (cmd)
    );

    bseq_step_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .order_in (linear_mode),
        .st       (st)
    );

    bseq_addr_reg #(.AW(AW)) u_areg (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr_in  (addr_in),
        .st       (st),
        .addr_out (addr_out)
    );

    assign burst_active = st.active;

    // R9
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> (addr_out[AW-1:STEP_W] == $past(addr_out[AW-1:STEP_W])));

    // R4
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_DESEL) |=> (!burst_active && $stable(addr_out)));

endmodule

// File: tb/bseq_burst_addr_bench.sv
`timescale 1ns/1ps
module bseq_burst_addr_bench;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          strobe_cpu, strobe_ctl, advance, chip_en, linear_mode;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference state
    logic [AW-1:0] m_base;
    int            m_cnt;
    logic          m_act;
    logic          m_lin;

    always #10 clk = ~clk;

    bseq_burst_addr #(.AW(AW)) u_bseq_burst_addr (
        .clk          (clk),
        .rst          (rst),
        .addr_in      (addr_in),
        .strobe_cpu   (strobe_cpu),
        .strobe_ctl   (strobe_ctl),
        .advance      (advance),
        .chip_en      (chip_en),
        .linear_mode  (linear_mode),
        .addr_out     (addr_out),
        .burst_active (burst_active)
    );

    function automatic logic [AW-1:0] exp_addr();
        int lo;
        int b;
        b = int'(m_base[1:0]);
        if (m_lin) lo = (b + m_cnt) % 4;
        else       lo = b ^ m_cnt;
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic check_out(input string tag);
        logic [AW-1:0] ea;
        ea = exp_addr();
        checks++;
        if (addr_out !== ea || burst_active !== m_act) begin
            errors++;
            $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                     tag, addr_out, burst_active, ea, m_act);
        end
    endtask

    // Called at a falling edge: drive, update reference, wait one edge, check.
    task automatic cyc(input logic [AW-1:0] a, input logic sp, input logic sc,
                       input logic adv, input logic ce, input logic lin,
                       input string tag);
        addr_in = a; strobe_cpu = sp; strobe_ctl = sc;
        advance = adv; chip_en = ce; linear_mode = lin;
        if (sp && ce) begin
            m_base = a; m_cnt = 0; m_act = 1'b1; m_lin = lin;
        end else if (sc) begin
            if (ce) begin
                m_base = a; m_cnt = 0; m_act = 1'b1; m_lin = lin;
            end else begin
                m_act = 1'b0;
            end
        end else if (adv && m_act) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; addr_in = '0; strobe_cpu = 0; strobe_ctl = 0;
        advance = 0; chip_en = 0; linear_mode = 0;
        m_base = '0; m_cnt = 0; m_act = 1'b0; m_lin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R1 reset");
        // reset applied with a load request pending must still clear
        addr_in = 20'hFFFFF; strobe_cpu = 1; chip_en = 1;
        @(posedge clk); @(negedge clk);
        check_out("R1 reset over strobe");
        rst = 1'b0;

        // linear burst from low bits 2: 2,3,0,1 then wrap to 2
        cyc(20'hABCDE, 1, 0, 0, 1, 1, "R2 cpu load");
        cyc('0, 0, 0, 1, 1, 1, "R6 linear step1");
        cyc('0, 0, 0, 1, 1, 1, "R6 linear step2");
        cyc('0, 0, 0, 1, 0, 0, "R10 mode change mid burst");
        cyc('0, 0, 0, 1, 1, 0, "R9 wrap to first word");
        cyc('0, 0, 0, 0, 1, 1, "R8 no advance hold");

        // interleaved burst from low bits 1: 1,0,3,2 then 1
        cyc(20'h13579, 0, 1, 0, 1, 0, "R3 ctl load");
        cyc('0, 0, 0, 1, 1, 0, "R7 xor step1");
        cyc('0, 0, 0, 1, 1, 1, "R7 xor step2");
        cyc('0, 0, 0, 1, 1, 0, "R7 xor step3");
        cyc('0, 0, 0, 1, 1, 0, "R9 xor wrap");

        // chip enable gating and deselect
        cyc(20'h00003, 1, 0, 0, 0, 1, "R4 cpu strobe ignored");
        cyc('0, 0, 0, 1, 1, 0, "R7 step after ignored strobe");
        cyc(20'h0F0F0, 0, 1, 0, 0, 1, "R4 ctl deselect");
        cyc('0, 0, 0, 1, 1, 1, "R8 advance while inactive");

        // both strobes, then mid-burst reload
        cyc(20'h55557, 1, 1, 0, 1, 1, "R5 both strobes");
        cyc('0, 0, 0, 1, 1, 1, "R6 step after both");
        cyc(20'h22222, 0, 1, 1, 1, 0, "R11 reload mid burst");
        cyc('0, 0, 0, 1, 1, 0, "R11 step after reload");

        // constrained random mix
        for (int i = 0; i < 500; i++) begin
            logic [AW-1:0] ra;
            int unsigned   r;
            ra = AW'($urandom);
            r  = $urandom;
            cyc(ra, (r % 8) == 0, ((r >> 3) % 6) == 0, ((r >> 6) % 4) != 0,
                ((r >> 8) % 5) != 0, r[12], "R11 random mix");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule